// File: doc/BRIEF.md
# Minimal 4-bit accumulator processor core

A small single-cycle processor that executes one 8-bit instruction per clock. Each instruction is fetched from a 16-entry program store at the address held in a 4-bit program counter. The core holds two 4-bit working registers (A and B), a 4-bit output register that drives the output port, and a carry flag. It can add an immediate to either register, move values between the registers, the immediate and the input port, drive the output port, and jump conditionally or unconditionally.

The program store is loaded through a write port that is honoured only while `rst_ni` is low. The first clock edge of each reset period clears the whole store, and words written later in the same reset period land on top of that. After `rst_ni` goes high, the first rising clock edge executes the word at address 0. Debug taps expose A, B, the program counter and the carry flag.

Top module: `nib_cpu`

## Requirements
- R1: While `rst_ni` is low, A, B, the program counter, the output register and carry all read 0 on the debug taps and `out_o`.
- R2: A program word has the opcode in bits 7:4 and the immediate in bits 3:0. A write to address `rom_addr_i` takes effect only at a clock edge where `rst_ni` is low; any entry not written during the latest reset period reads as 0x00.
- R3: ADD A,Im (0000) and ADD B,Im (0101) write (reg + Im) mod 16 into the named register and bit 4 of the 5-bit raw sum into carry.
- R4: Carry changes only on the two ADD opcodes and holds its value through every other instruction, with no automatic clearing.
- R5: MOV A,B (0001) copies B to A; MOV B,A (0100) copies A to B; MOV A,Im (0011) and MOV B,Im (0111) load the immediate; IN A (0010) and IN B (0110) load `in_i` as sampled at the executing edge.
- R6: OUT B (1000) loads B into the output register, OUT Im (1001) loads the immediate, and `out_o` changes on no other opcode.
- R7: Opcodes 1010, 1011, 1100 and 1101 leave A, B, the output register and carry unchanged and only advance the program counter.
- R8: JNC Im (1110) loads the program counter with Im when carry is 0 and advances it by one when carry is 1.
- R9: JMP Im (1111) always loads the program counter with Im; every opcode other than 1110 and 1111 advances it by one, wrapping from 15 to 0.
- R10: Exactly one instruction completes per rising clock edge, using the word stored at the current program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; also enables program loading |
| in_i | input | 4 | Input port read by IN A / IN B |
| out_o | output | 4 | Output port, driven by the output register |
| rom_we_i | input | 1 | Program store write enable (effective only in reset) |
| rom_addr_i | input | 4 | Program store write address |
| rom_data_i | input | 8 | Program store write data |
| dbg_a_o | output | 4 | Register A |
| dbg_b_o | output | 4 | Register B |
| dbg_pc_o | output | 4 | Program counter |
| dbg_carry_o | output | 1 | Carry flag |

## Verification
The hardest state to reach from the ports is a set carry that has to survive a run of unrelated instructions and then steer a JNC. This matters because a flag that is cleared every cycle would still pass most simple programs. The stimulus reaches it with an ADD whose raw sum is exactly 16, follows it with the four no-op opcodes and a JNC that must fall through, and then runs a small ADD that clears carry so that a second JNC is taken. Writes that arrive outside reset are exposed by rewriting an address the running program is about to fetch and checking that the output port keeps its old value.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD_A  = 4'b0000,
    OP_MOV_AB = 4'b0001,
    OP_IN_A   = 4'b0010,
    OP_LDI_A  = 4'b0011,
    OP_MOV_BA = 4'b0100,
    OP_ADD_B  = 4'b0101,
    OP_IN_B   = 4'b0110,
    OP_LDI_B  = 4'b0111,
    OP_OUT_B  = 4'b1000,
    OP_OUT_I  = 4'b1001,
    OP_NOP_A  = 4'b1010,
    OP_NOP_B  = 4'b1011,
    OP_NOP_C  = 4'b1100,
    OP_NOP_D  = 4'b1101,
    OP_JNC    = 4'b1110,
    OP_JMP    = 4'b1111
  } op_e;

  // register source select
  typedef enum logic [2:0] {
    SRC_KEEP,
    SRC_SUM,
    SRC_XFER,
    SRC_PORT,
    SRC_IMM
  } src_e;

  typedef enum logic [1:0] {
    OSRC_KEEP,
    OSRC_B,
    OSRC_IMM
  } osrc_e;

  typedef struct packed {
    src_e  a_src;
    src_e  b_src;
    osrc_e out_src;
    logic  carry_we;
    logic  alu_b;    // adder operand: 0 = A, 1 = B
    logic  pc_load;
  } ctrl_t;

endpackage

// File: rtl/nib_rom.sv
module nib_rom #(
  parameter int AW = 4,
  parameter int IW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);

  logic             run_q;
  logic             wipe;
  logic             wr_en;
  logic [IW-1:0]    mem_q [DEPTH];

  // remembers whether the previous edge saw the core running
  always_ff @(posedge clk_i) run_q <= rst_ni;

  assign wipe  = ~rst_ni & run_q;
  assign wr_en = ~rst_ni & we_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_en && waddr_i == AW'(i)) mem_q[i] <= wdata_i;
      else if (wipe)                  mem_q[i] <= '0;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/nib_decode.sv
module nib_decode
  import nib_cpu_pkg::*;
(
  input  op_e   op_i,
  input  logic  carry_i,
  output ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.a_src    = SRC_KEEP;
    ctrl_o.b_src    = SRC_KEEP;
    ctrl_o.out_src  = OSRC_KEEP;
    unique case (op_i)
      OP_ADD_A:  begin ctrl_o.a_src = SRC_SUM; ctrl_o.carry_we = 1'b1; end
      OP_MOV_AB: ctrl_o.a_src = SRC_XFER;
      OP_IN_A:   ctrl_o.a_src = SRC_PORT;
      OP_LDI_A:  ctrl_o.a_src = SRC_IMM;
      OP_MOV_BA: ctrl_o.b_src = SRC_XFER;
      OP_ADD_B:  begin
        ctrl_o.b_src    = SRC_SUM;
        ctrl_o.carry_we = 1'b1;
        ctrl_o.alu_b    = 1'b1;
      end
      OP_IN_B:   ctrl_o.b_src = SRC_PORT;
      OP_LDI_B:  ctrl_o.b_src = SRC_IMM;
      OP_OUT_B:  ctrl_o.out_src = OSRC_B;
      OP_OUT_I:  ctrl_o.out_src = OSRC_IMM;
      OP_JNC:    ctrl_o.pc_load = ~carry_i;
      OP_JMP:    ctrl_o.pc_load = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/nib_alu.sv
module nib_alu #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sel_b_i,
  input  logic [DW-1:0] imm_i,
  output logic [DW-1:0] sum_o,
  output logic          co_o
);

  logic [DW-1:0] opnd;
  logic [DW:0]   raw;

  assign opnd          = sel_b_i ? b_i : a_i;
  assign raw           = {1'b0, opnd} + {1'b0, imm_i};
  assign {co_o, sum_o} = raw;

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_cpu_pkg::*;
#(
  parameter int DW = 4,
  localparam int IW = OPW + DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] in_i,
  output logic [DW-1:0] out_o,
  input  logic          rom_we_i,
  input  logic [DW-1:0] rom_addr_i,
  input  logic [IW-1:0] rom_data_i,
  output logic [DW-1:0] dbg_a_o,
  output logic [DW-1:0] dbg_b_o,
  output logic [DW-1:0] dbg_pc_o,
  output logic          dbg_carry_o
);

  logic [DW-1:0] a_q, b_q, pc_q, out_q;
  logic          carry_q;
  logic [IW-1:0] instr_w;
  logic [DW-1:0] imm;
  op_e           op;
  ctrl_t         ctrl;
  logic [DW-1:0] sum;
  logic          co;

  nib_rom #(.AW(DW), .IW(IW)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rom_we_i),
    .waddr_i (rom_addr_i),
    .wdata_i (rom_data_i),
    .raddr_i (pc_q),
    .rdata_o (instr_w)
  );

  assign op  = op_e'(instr_w[IW-1:DW]);
  assign imm = instr_w[DW-1:0];

  nib_decode u_dec (
    .op_i    (op),
    .carry_i (carry_q),
    .ctrl_o  (ctrl)
  );

  nib_alu #(.DW(DW)) u_alu (
    .a_i     (a_q),
    .b_i     (b_q),
    .sel_b_i (ctrl.alu_b),
    .imm_i   (imm),
    .sum_o   (sum),
    .co_o    (co)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      pc_q    <= '0;
      out_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      unique case (ctrl.a_src)
        SRC_SUM:  a_q <= sum;
        SRC_XFER: a_q <= b_q;
        SRC_PORT: a_q <= in_i;
        SRC_IMM:  a_q <= imm;
        default:  ;
      endcase
      unique case (ctrl.b_src)
        SRC_SUM:  b_q <= sum;
        SRC_XFER: b_q <= a_q;
        SRC_PORT: b_q <= in_i;
        SRC_IMM:  b_q <= imm;
        default:  ;
      endcase
      unique case (ctrl.out_src)
        OSRC_B:   out_q <= b_q;
        OSRC_IMM: out_q <= imm;
        default:  ;
      endcase
      if (ctrl.carry_we) carry_q <= co;
      pc_q <= ctrl.pc_load ? imm : pc_q + 1'b1;
    end
  end

  assign out_o       = out_q;
  assign dbg_a_o     = a_q;
  assign dbg_b_o     = b_q;
  assign dbg_pc_o    = pc_q;
  assign dbg_carry_o = carry_q;

endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk #(
  parameter int DW = 4,
  localparam int IW = DW + 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] instr_w,
  input logic [DW-1:0] out_o,
  input logic [DW-1:0] dbg_a_o,
  input logic [DW-1:0] dbg_b_o,
  input logic [DW-1:0] dbg_pc_o,
  input logic          dbg_carry_o
);

  logic [3:0]    opc;
  logic [DW-1:0] imm;
  assign opc = instr_w[IW-1:DW];
  assign imm = instr_w[DW-1:0];

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (dbg_a_o == '0 && dbg_b_o == '0 && dbg_pc_o == '0 &&
                 out_o == '0 && !dbg_carry_o));

  a_r3_add_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc == 4'b0000 |=> {dbg_carry_o, dbg_a_o} ==
      ({1'b0, $past(dbg_a_o)} + {1'b0, $past(imm)}));

  a_r4_carry_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc != 4'b0000 && opc != 4'b0101) |=> $stable(dbg_carry_o));

  a_r6_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc != 4'b1000 && opc != 4'b1001) |=> $stable(out_o));

  a_r7_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc[3:2] == 2'b11 && !opc[1] || opc[3:1] == 3'b101 |=>
      ($stable(dbg_a_o) && $stable(dbg_b_o) && $stable(out_o) && $stable(dbg_carry_o)));

  a_r8_jnc_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == 4'b1110 && !dbg_carry_o) |=> dbg_pc_o == $past(imm));

  a_r9_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc[3:1] != 3'b111 || (opc == 4'b1110 && dbg_carry_o)) |=>
      dbg_pc_o == $past(dbg_pc_o) + 1'b1);

endmodule

bind nib_cpu nib_cpu_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_w     (instr_w),
  .out_o       (out_o),
  .dbg_a_o     (dbg_a_o),
  .dbg_b_o     (dbg_b_o),
  .dbg_pc_o    (dbg_pc_o),
  .dbg_carry_o (dbg_carry_o)
);

// File: tb/tb_nib_cpu.sv
module tb_nib_cpu;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [3:0] in_i = '0;
  logic [3:0] out_o;
  logic       rom_we_i = 1'b0;
  logic [3:0] rom_addr_i = '0;
  logic [7:0] rom_data_i = '0;
  logic [3:0] dbg_a_o, dbg_b_o, dbg_pc_o;
  logic       dbg_carry_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  nib_cpu dut (
    .clk_i, .rst_ni, .in_i, .out_o,
    .rom_we_i, .rom_addr_i, .rom_data_i,
    .dbg_a_o, .dbg_b_o, .dbg_pc_o, .dbg_carry_o
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int a, input int b,
                           input int pc, input int o, input int c);
    chk({tag, " A"}, dbg_a_o, a);
    chk({tag, " B"}, dbg_b_o, b);
    chk({tag, " PC"}, dbg_pc_o, pc);
    chk({tag, " OUT"}, out_o, o);
    chk({tag, " C"}, dbg_carry_o, c);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // loads words at listed addresses during reset, then releases it
  task automatic load(input logic [3:0] addr[$], input logic [7:0] data[$]);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    foreach (data[i]) begin
      rom_we_i   = 1'b1;
      rom_addr_i = addr[i];
      rom_data_i = data[i];
      @(negedge clk_i);
    end
    rom_we_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    step(2);
    chk_state("R1 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_counter;
    load('{0, 1, 2}, '{8'h30, 8'h01, 8'hF1});
    step(1);
    chk_state("R10 first", 0, 0, 1, 0, 0);
    step(29);
    chk_state("R3 count15", 15, 0, 2, 0, 0);
    step(2);
    chk_state("R3 rollover", 0, 0, 2, 0, 1);
    step(1);
    chk_state("R4 carry kept over JMP R9", 0, 0, 1, 0, 1);
  endtask

  task automatic t_moves;
    in_i = 4'hB;
    load('{0, 1, 2, 3, 4, 5, 6, 7, 8},
         '{8'h35, 8'h40, 8'h5C, 8'h10, 8'h80, 8'h99, 8'h20, 8'h60, 8'hF8});
    step(1); chk_state("R5 ldi A", 5, 0, 1, 0, 0);
    step(1); chk_state("R5 mov B,A", 5, 5, 2, 0, 0);
    step(1); chk_state("R3 add B wrap", 5, 1, 3, 0, 1);
    step(1); chk_state("R5 mov A,B R4", 1, 1, 4, 0, 1);
    step(1); chk_state("R6 out B", 1, 1, 5, 1, 1);
    step(1); chk_state("R6 out imm", 1, 1, 6, 9, 1);
    in_i = 4'h6;
    step(1); chk_state("R5 in A", 6, 1, 7, 9, 1);
    in_i = 4'h3;
    step(1); chk_state("R5 in B", 6, 3, 8, 9, 1);
    step(2); chk_state("R9 jmp self", 6, 3, 8, 9, 1);
  endtask

  task automatic t_nop_jnc;
    load('{0, 1, 2, 3, 4, 5, 6, 7, 8},
         '{8'h37, 8'h09, 8'hA3, 8'hB4, 8'hC5, 8'hD6, 8'hE0, 8'h01, 8'hE3});
    step(2); chk_state("R3 sum16", 0, 0, 2, 0, 1);
    step(2); chk_state("R7 nop A/B", 0, 0, 4, 0, 1);
    step(2); chk_state("R7 nop C/D R4", 0, 0, 6, 0, 1);
    step(1); chk_state("R8 jnc falls", 0, 0, 7, 0, 1);
    step(1); chk_state("R3 add clears c", 1, 0, 8, 0, 0);
    step(1); chk_state("R8 jnc taken", 1, 0, 3, 0, 0);
  endtask

  task automatic t_wrap_and_lock;
    load('{15}, '{8'h9F});
    step(15); chk_state("R2 wiped words", 0, 0, 15, 0, 0);
    step(1);  chk_state("R9 wrap", 0, 0, 0, 15, 0);
    rom_we_i   = 1'b1;
    rom_addr_i = 4'd1;
    rom_data_i = 8'h95;
    step(1);
    rom_we_i = 1'b0;
    chk_state("R2 run write", 0, 0, 1, 15, 0);
    step(1); chk_state("R2 write ignored", 0, 0, 2, 15, 0);
  endtask

  initial begin
    step(2);
    t_reset();
    t_counter();
    t_moves();
    t_nop_jnc();
    t_wrap_and_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule